// File: doc/BRIEF.md
# Serial ECC Read Request Register

This block is a small memory-mapped control register that lets software fetch one word of status from a remote RAM checker over a narrow serial status bus. Software writes a single control word holding the target RAM identifier, an 8-bit remote read address and a set-only start bit. The block then sends one single-cycle request, carrying the identifier and address, to the serial-bus side. It waits there for a completion strobe.

When the strobe arrives, the block captures the returned word into a separate read-only data register and raises a sticky completion flag. Software polls that flag and clears it again with any write to the control word. If the remote side stays silent for a parameterised number of cycles, the block gives up, emits a one-cycle timeout pulse and returns to idle.

Register reads go through a simple port with one cycle of latency. Word address 0 is the control word and word address 1 is the captured data.

Top module: `ecc_rdreq_top`

## Requirements
- R1: After reset the control word and the data register both read 0, and no request is issued.
- R2: Control bits 10:0 (RAM identifier) and bits 23:16 (remote read address) are plain read/write fields and read back the last written value.
- R3: Control bits 31:25 and 14:11 always read 0, whatever was written to them.
- R4: A write of 1 to control bit 15 while idle drives `srl_req` high for exactly one cycle, the cycle right after the write. The request carries the written RAM identifier on `srl_ram` and the written address on `srl_addr`. Writing 0 to bit 15 has no effect on it.
- R5: Control bit 15 reads 1 from the write that starts a read until the read completes or times out, and reads 0 afterwards.
- R6: A start written while a read is in flight is ignored: no second request is issued.
- R7: A `srl_done` strobe sampled while a read is in flight sets control bit 24, which stays set. The same strobe captures `srl_rdata` into the data register at word address 1.
- R8: Any write to the control word clears bit 24. If a completion strobe is accepted on the same edge as such a write, the flag ends up set.
- R9: If no strobe is accepted within TIMEOUT_CYC clock edges after the request cycle begins, `tmo_pulse` is high for one cycle, exactly TIMEOUT_CYC cycles after the request cycle. Bit 15 then clears, while bit 24 and the data register stay unchanged. A strobe on the last of those edges still counts as completion.
- R10: A `srl_done` strobe while no read is in flight is ignored; bit 24 and the data register keep their values.
- R11: `rd_data` shows the addressed word on the cycle after `rd_en`. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Registered read data |
| srl_req | output | 1 | One-cycle read request to the serial side |
| srl_ram | output | 11 | RAM identifier sent with the request |
| srl_addr | output | 8 | Remote read address sent with the request |
| srl_done | input | 1 | Completion strobe from the serial side |
| srl_rdata | input | DATA_W | Word returned with the completion strobe |
| tmo_pulse | output | 1 | One-cycle pulse when a read times out |

## Verification
The read path is run with several response delays. With zero delay, completion follows straight after the request. A mid-range delay leaves room to try a second start while the first read is still busy. The longest delay puts completion on the same edge as the timeout limit, so only correct done-over-timeout priority passes. One cycle more forces a timeout instead, and the late strobe that follows then lands on an idle block, which tells apart a design that ignores stray strobes from one that latches them. A control write timed onto the completion edge separates set-wins from clear-wins on the sticky flag. Changing identifier and address patterns between reads exposes swapped or stale request fields.

// File: rtl/ecc_rdreq_pkg.sv
package ecc_rdreq_pkg;
  // control word layout
  localparam int RAM_LSB  = 0;
  localparam int RAM_W    = 11;
  localparam int RADR_LSB = 16;
  localparam int RADR_W   = 8;
  localparam int START_B  = 15;
  localparam int DONE_B   = 24;
  localparam int REG_W    = 32;

  // word addresses
  localparam int OFS_CTRL = 0;
  localparam int OFS_DATA = 1;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_WAIT = 1'b1} sq_state_e;
endpackage

// File: rtl/ecc_rdreq_seq.sv
module ecc_rdreq_seq
  import ecc_rdreq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RAM_W-1:0]  start_ram_i,
  input  logic [RADR_W-1:0] start_addr_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [RAM_W-1:0]  req_ram_o,
  output logic [RADR_W-1:0] req_addr_o,
  output logic              done_evt_o,
  output logic              tmo_evt_o,
  output logic              tmo_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  sq_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    done_evt_o = (st_q == SQ_WAIT) && done_i;
    tmo_evt_o  = (st_q == SQ_WAIT) && !done_i && (cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SQ_IDLE;
      cnt_q      <= '0;
      req_o      <= 1'b0;
      req_ram_o  <= '0;
      req_addr_o <= '0;
      tmo_o      <= 1'b0;
    end else begin
      req_o <= 1'b0;
      tmo_o <= tmo_evt_o;
      case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            req_o      <= 1'b1;
            req_ram_o  <= start_ram_i;
            req_addr_o <= start_addr_i;
            cnt_q      <= '0;
            st_q       <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (done_evt_o || tmo_evt_o) st_q <= SQ_IDLE;
          else                         cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R4: request lasts a single cycle
  a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  // R9: timeout is a single-cycle pulse
  a_r9_tmo_single: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> !tmo_o);
  // R6: no request leaves while a read waits
  a_r6_no_req_in_wait: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_WAIT && !done_evt_o && !tmo_evt_o) |=> !req_o);
endmodule

// File: rtl/ecc_rdreq_regs.sv
module ecc_rdreq_regs
  import ecc_rdreq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              done_evt_i,
  input  logic              tmo_evt_i,
  input  logic [DATA_W-1:0] done_data_i,
  output logic              start_o,
  output logic [RAM_W-1:0]  start_ram_o,
  output logic [RADR_W-1:0] start_addr_o,
  output logic              busy_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic [RAM_W-1:0]  ram_q;
  logic [RADR_W-1:0] radr_q;
  logic              start_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic              ctrl_wr;
  logic [REG_W-1:0]  ctrl_word;

  always_comb begin
    ctrl_wr      = wr_en && (wr_addr == A_CTRL);
    start_o      = ctrl_wr && wr_data[START_B] && !start_q;
    start_ram_o  = wr_data[RAM_LSB +: RAM_W];
    start_addr_o = wr_data[RADR_LSB +: RADR_W];
    busy_o       = start_q;
    ctrl_word                         = '0;
    ctrl_word[RAM_LSB +: RAM_W]       = ram_q;
    ctrl_word[RADR_LSB +: RADR_W]     = radr_q;
    ctrl_word[START_B]                = start_q;
    ctrl_word[DONE_B]                 = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_q   <= '0;
      radr_q  <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      rd_data <= '0;
    end else begin
      if (ctrl_wr) begin
        ram_q  <= wr_data[RAM_LSB +: RAM_W];
        radr_q <= wr_data[RADR_LSB +: RADR_W];
      end
      if (start_o)                      start_q <= 1'b1;
      else if (done_evt_i || tmo_evt_i) start_q <= 1'b0;
      if (done_evt_i) begin
        done_q <= 1'b1;
        data_q <= done_data_i;
      end else if (ctrl_wr) begin
        done_q <= 1'b0;
      end
      if (rd_en) begin
        if (rd_addr == A_CTRL)      rd_data <= ctrl_word;
        else if (rd_addr == A_DATA) rd_data <= REG_W'(data_q);
        else                        rd_data <= '0;
      end
    end
  end

  // R7: accepted completion leaves the flag set
  a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    done_evt_i |=> done_q);
  // R8: a control write without completion clears the flag
  a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !done_evt_i) |=> !done_q);
  // R5: start bit holds until completion or timeout
  a_r5_start_holds: assert property (@(posedge clk) disable iff (rst)
    (start_q && !done_evt_i && !tmo_evt_i) |=> start_q);
  // R10: flag never rises without a completion event
  a_r10_flag_needs_evt: assert property (@(posedge clk) disable iff (rst)
    (!done_q && !done_evt_i) |=> !done_q);
endmodule

// File: rtl/ecc_rdreq_top.sv
module ecc_rdreq_top
  import ecc_rdreq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              srl_req,
  output logic [10:0]       srl_ram,
  output logic [7:0]        srl_addr,
  input  logic              srl_done,
  input  logic [DATA_W-1:0] srl_rdata,
  output logic              tmo_pulse
);
  logic              start;
  logic [RAM_W-1:0]  start_ram;
  logic [RADR_W-1:0] start_addr;
  logic              busy;
  logic              done_evt;
  logic              tmo_evt;

  ecc_rdreq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done_evt_i(done_evt), .tmo_evt_i(tmo_evt), .done_data_i(srl_rdata),
    .start_o(start), .start_ram_o(start_ram), .start_addr_o(start_addr),
    .busy_o(busy)
  );

  ecc_rdreq_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst(rst),
    .start_i(start), .start_ram_i(start_ram), .start_addr_i(start_addr),
    .done_i(srl_done),
    .req_o(srl_req), .req_ram_o(srl_ram), .req_addr_o(srl_addr),
    .done_evt_o(done_evt), .tmo_evt_o(tmo_evt), .tmo_o(tmo_pulse)
  );

  // R4: a request only leaves while the start bit shows a read in flight
  a_r4_req_busy: assert property (@(posedge clk) disable iff (rst)
    srl_req |-> busy);
  // R9: timeout pulse follows a cleared start bit
  a_r9_tmo_idle: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> !busy || $past(start));
endmodule

// File: tb/sim_ecc_rdreq_top.sv
module sim_ecc_rdreq_top;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        srl_req, tmo_pulse;
  logic [10:0] srl_ram;
  logic [7:0]  srl_addr;
  logic        srl_done = 1'b0;
  logic [31:0] srl_rdata = '0;

  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  int cyc = 0, t_req = 0, tmo_cnt = 0, tmo_gap = 0;
  int resp_dly = 0;
  bit resp_pend = 0;
  int resp_cnt = 0;
  logic [10:0] resp_ram;
  logic [7:0]  resp_adr;
  logic [18:0] exp_q[$];

  always #2 clk = ~clk;

  ecc_rdreq_top #(.ADDR_W(2), .DATA_W(32), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .srl_req(srl_req), .srl_ram(srl_ram), .srl_addr(srl_addr),
    .srl_done(srl_done), .srl_rdata(srl_rdata), .tmo_pulse(tmo_pulse)
  );

  function automatic logic [31:0] pat(input logic [10:0] r, input logic [7:0] a);
    return {8'hC3, 5'b0, r, a};
  endfunction

  // monitor + stub responder (all at negedge)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    srl_done <= 1'b0;
    if (!rst && srl_req) begin
      t_req <= cyc;
      mon_checks <= mon_checks + 1;
      if (exp_q.size() == 0) begin
        mon_fails <= mon_fails + 1;
        $display("FAIL R6 unexpected request act=%h/%h exp=none", srl_ram, srl_addr);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        if ({srl_ram, srl_addr} !== e) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R4 request fields act=%h exp=%h", {srl_ram, srl_addr}, e);
        end
      end
      resp_pend <= 1'b1; resp_cnt <= resp_dly;
      resp_ram <= srl_ram; resp_adr <= srl_addr;
    end else if (resp_pend) begin
      if (resp_cnt == 0) begin
        srl_done <= 1'b1; srl_rdata <= pat(resp_ram, resp_adr); resp_pend <= 1'b0;
      end else resp_cnt <= resp_cnt - 1;
    end
    if (!rst && tmo_pulse) begin
      tmo_cnt <= tmo_cnt + 1; tmo_gap <= cyc - t_req;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  function automatic logic [31:0] cw(input logic [10:0] r, input logic [7:0] a,
                                     input bit s, input bit dn);
    return {7'b0, dn, a, s, 4'b0, r};
  endfunction

  // driver: pushes the expected request, then writes the start
  task automatic launch(input logic [10:0] r, input logic [7:0] a, input int dly);
    resp_dly = dly;
    exp_q.push_back({r, a});
    wr(2'd0, cw(r, a, 1'b1, 1'b0));
  endtask

  task automatic finish_run;
    chk("R4 all requests seen", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  endtask

  initial begin
    #(4ns * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int t0;
    repeat (4) @(negedge clk);
    chk("R1 no request in reset", 32'(srl_req), 32'd0);
    rst = 1'b0;
    rd(2'd0, v); chk("R1 ctrl reset", v, 32'h0);
    rd(2'd1, v); chk("R1 data reset", v, 32'h0);

    // R2/R3 fields and reserved bits, no start
    wr(2'd0, 32'hFFFF_7FFF);
    rd(2'd0, v); chk("R3 reserved read 0", v, 32'h00FF_07FF);
    wr(2'd0, cw(11'h5A3, 8'h7E, 1'b0, 1'b0) | 32'hFE00_7800 & ~32'h0000_8000);
    rd(2'd0, v); chk("R2 field readback", v, cw(11'h5A3, 8'h7E, 1'b0, 1'b0));

    // R4/R5/R6/R7 normal read with retrigger while busy
    launch(11'h123, 8'h45, 6);
    rd(2'd0, v); chk("R5 start reads 1 in flight", 32'(v[15]), 32'd1);
    wr(2'd0, cw(11'h321, 8'h54, 1'b1, 1'b0));   // R6: ignored start
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R7 done flag set, R5 start clear", v, cw(11'h321, 8'h54, 1'b0, 1'b1));
    rd(2'd1, v); chk("R7 data captured", v, pat(11'h123, 8'h45));

    // R8 any write clears the flag
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); chk("R8 write clears done", v, 32'h0);

    // zero delay
    launch(11'h7FF, 8'h00, 0);
    repeat (6) @(negedge clk);
    rd(2'd1, v); chk("R7 zero-delay data", v, pat(11'h7FF, 8'h00));

    // longest delay: completion on the timeout edge
    t0 = tmo_cnt;
    launch(11'h001, 8'hFF, TMO - 2);
    repeat (TMO + 6) @(negedge clk);
    rd(2'd0, v); chk("R9 done on last edge wins", 32'(v[24]), 32'd1);
    chk("R9 no timeout at limit", 32'(tmo_cnt - t0), 32'd0);
    rd(2'd1, v); chk("R7 limit data", v, pat(11'h001, 8'hFF));

    // timeout, then stray late strobe hits idle block
    launch(11'h2AA, 8'h55, TMO - 1);
    repeat (TMO + 6) @(negedge clk);
    chk("R9 one timeout", 32'(tmo_cnt - t0), 32'd1);
    chk("R9 timeout distance", 32'(tmo_gap), 32'(TMO));
    rd(2'd0, v); chk("R9 start clear, R10 flag untouched", v, cw(11'h2AA, 8'h55, 1'b0, 1'b0));
    rd(2'd1, v); chk("R10 data unchanged", v, pat(11'h001, 8'hFF));

    // R8 collision: control write on the completion edge
    launch(11'h0F0, 8'h0F, 3);
    repeat (3) @(negedge clk);
    wr(2'd0, cw(11'h0F0, 8'h0F, 1'b0, 1'b0));
    rd(2'd0, v); chk("R8 set wins over clear", 32'(v[24]), 32'd1);

    // R11 unmapped address
    rd(2'd2, v); chk("R11 unmapped reads 0", v, 32'h0);
    rd(2'd3, v); chk("R11 unmapped reads 0 (3)", v, 32'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule